// File: doc/BRIEF.md
# Limp-Home Signal Generator

This block drives the two fail-safe lamp outputs of a system supervisor after the supervisor has given up on its host processor. Once limp-home mode is entered, two open-drain style outputs start running. The side-indicator output blinks slowly at 1.25 Hz with an even on/off split. The lamp output produces a 100 Hz PWM that pulls low for one fifth of each period and is released for the rest, which dims a lamp. Each output is an enable: 1 means the pin is pulled low, and 0 means it is released (high impedance).

Entry into limp-home mode has two sources. The first is the watchdog-failure pulse. A configuration input chooses whether one failure is enough or whether two consecutive failures are needed. A valid watchdog service between two failures breaks the run of failures. The second source is an explicit activation flag. The mode then holds until a clear command arrives. Both waveforms come from the one input clock through integer dividers, so the clock frequency is a parameter and is the only timing input. The clock frequency must be a multiple of 500 Hz.

Top module: `limp_sig_gen`

## Requirements
- R1: After reset, limp_active is 0 and both si_drive_low and pl_drive_low are 0 (released).
- R2: With two_fail_cfg = 0, one wd_fail pulse sets limp_active to 1 at the next clock edge.
- R3: With two_fail_cfg = 1, the first wd_fail pulse leaves limp_active at 0. The second consecutive wd_fail pulse sets it to 1 at the next edge.
- R4: A wd_ok pulse between two failures resets the failure count, so in two-failure mode the sequence fail, ok, fail does not activate. A further fail then does. If wd_fail and wd_ok arrive in the same cycle, the failure wins.
- R5: A force_on pulse sets limp_active to 1 at the next edge, whatever the failure count and the configuration.
- R6: While active, si_drive_low has a period of 4*CLK_HZ/5 cycles. It is 1 for the first 2*CLK_HZ/5 cycles of each period and 0 for the rest, and the first cycle is the one in which limp_active rises.
- R7: While active, pl_drive_low has a period of CLK_HZ/100 cycles. It is 1 for the first CLK_HZ/500 cycles of each period and 0 for the rest, and its phase starts with limp_active as in R6.
- R8: Once active, the block stays active until clear. Further wd_fail or force_on pulses do not restart the phase of either waveform.
- R9: A clear pulse sets limp_active to 0 at the next edge and resets the failure count. Clear takes priority over a wd_fail or force_on in the same cycle.
- R10: While limp_active is 0, both drive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| wd_fail | input | 1 | One-cycle watchdog failure pulse |
| wd_ok | input | 1 | One-cycle valid watchdog service pulse |
| two_fail_cfg | input | 1 | 0: one failure activates; 1: two consecutive failures |
| force_on | input | 1 | Explicit activation pulse |
| clear | input | 1 | Leave limp-home mode and reset the failure count |
| si_drive_low | output | 1 | Side-indicator pin pulled low when 1 |
| pl_drive_low | output | 1 | Lamp PWM pin pulled low when 1 |
| limp_active | output | 1 | Limp-home mode status |

## Verification
The bench compares every cycle of several full blink periods and many PWM periods against counts computed from CLK_HZ. A divider that is off by one would drift away from these counts, and a waveform that started in the released phase would fail in the first cycle. A failure and a force pulse are injected in the middle of a waveform. A design that reset its dividers on these pulses would jump back to phase zero and fail the comparison. The two-failure mode is tested with an interleaved service pulse, which catches a counter that is never cleared. Clear is tested both alone and in the same cycle as a failure and a force pulse. A design with the wrong priority would stay active.

// File: rtl/limp_pkg.sv
package limp_pkg;
  // Blink: 1.25 Hz -> period 0.8 s, half of it driven low
  function automatic int si_period(input int clk_hz);
    return (clk_hz * 4) / 5;
  endfunction
  function automatic int si_low(input int clk_hz);
    return (clk_hz * 2) / 5;
  endfunction
  // Lamp PWM: 100 Hz, driven low 20 %
  function automatic int pl_period(input int clk_hz);
    return clk_hz / 100;
  endfunction
  function automatic int pl_low(input int clk_hz);
    return clk_hz / 500;
  endfunction
endpackage

// File: rtl/limp_entry.sv
module limp_entry (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_fail,
  input  logic wd_ok,
  input  logic two_fail_cfg,
  input  logic force_on,
  input  logic clear,
  output logic active,
  output logic armed,
  output logic trip
);
  logic fail_trip;

  // a failure that completes the entry condition
  assign fail_trip = wd_fail && (!two_fail_cfg || armed);
  assign trip      = !clear && (fail_trip || force_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      armed  <= 1'b0;
    end else if (clear) begin
      active <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (fail_trip || force_on) active <= 1'b1;
      if (wd_fail)    armed <= two_fail_cfg && !armed;
      else if (wd_ok) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/limp_divider.sv
module limp_divider #(
  parameter int PERIOD = 20,
  parameter int LOW    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic low_phase,
  output logic wrap
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] LOWC = CW'(LOW);

  logic [CW-1:0] cnt;

  assign wrap      = run && (cnt == LAST);
  assign low_phase = run && (cnt < LOWC);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (wrap)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/limp_sig_gen.sv
module limp_sig_gen #(
  parameter int CLK_HZ = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_fail,
  input  logic wd_ok,
  input  logic two_fail_cfg,
  input  logic force_on,
  input  logic clear,
  output logic si_drive_low,
  output logic pl_drive_low,
  output logic limp_active
);
  localparam int SI_PER = limp_pkg::si_period(CLK_HZ);
  localparam int SI_LOW = limp_pkg::si_low(CLK_HZ);
  localparam int PL_PER = limp_pkg::pl_period(CLK_HZ);
  localparam int PL_LOW = limp_pkg::pl_low(CLK_HZ);

  logic active, armed, trip;
  logic si_wrap, pl_wrap;

  limp_entry u_entry (
    .clk(clk), .rst_n(rst_n), .wd_fail(wd_fail), .wd_ok(wd_ok),
    .two_fail_cfg(two_fail_cfg), .force_on(force_on), .clear(clear),
    .active(active), .armed(armed), .trip(trip)
  );

  limp_divider #(.PERIOD(SI_PER), .LOW(SI_LOW)) u_si_div (
    .clk(clk), .rst_n(rst_n), .run(active),
    .low_phase(si_drive_low), .wrap(si_wrap)
  );

  limp_divider #(.PERIOD(PL_PER), .LOW(PL_LOW)) u_pl_div (
    .clk(clk), .rst_n(rst_n), .run(active),
    .low_phase(pl_drive_low), .wrap(pl_wrap)
  );

  assign limp_active = active;
endmodule

// File: rtl/limp_sig_gen_chk.sv
module limp_sig_gen_chk #(
  parameter int CLK_HZ = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic wd_fail,
  input logic wd_ok,
  input logic two_fail_cfg,
  input logic force_on,
  input logic clear,
  input logic si_drive_low,
  input logic pl_drive_low,
  input logic limp_active,
  input logic armed,
  input logic trip,
  input logic pl_wrap,
  input logic si_wrap
);
  localparam int PL_LOW = limp_pkg::pl_low(CLK_HZ);
  localparam int SI_LOW = limp_pkg::si_low(CLK_HZ);

  logic [31:0] pl_run, si_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_run <= '0;
      si_run <= '0;
    end else begin
      pl_run <= pl_drive_low ? pl_run + 1 : '0;
      si_run <= si_drive_low ? si_run + 1 : '0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !limp_active);
  a_r2_single_trip: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fail && !two_fail_cfg && !clear |=> limp_active);
  a_r3_first_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fail && two_fail_cfg && !armed && !force_on && !clear && !limp_active |=> !limp_active);
  a_r4_ok_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ok && !wd_fail |=> !armed);
  a_r5_force: assert property (@(posedge clk) disable iff (!rst_n)
    force_on && !clear |=> limp_active);
  a_r6_si_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(limp_active) |-> si_drive_low && pl_drive_low);
  a_r6_si_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    limp_active && $past(si_drive_low) && !si_drive_low |-> si_run == SI_LOW);
  a_r7_pl_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    limp_active && $past(pl_drive_low) && !pl_drive_low |-> pl_run == PL_LOW);
  a_r7_pl_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    pl_wrap && !clear |=> pl_drive_low);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    limp_active && !clear |=> limp_active);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !limp_active && !armed && !trip);
  a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
    !limp_active |-> !si_drive_low && !pl_drive_low && !si_wrap);
endmodule

bind limp_sig_gen limp_sig_gen_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_fail(wd_fail), .wd_ok(wd_ok),
  .two_fail_cfg(two_fail_cfg), .force_on(force_on), .clear(clear),
  .si_drive_low(si_drive_low), .pl_drive_low(pl_drive_low),
  .limp_active(limp_active), .armed(armed), .trip(trip),
  .pl_wrap(pl_wrap), .si_wrap(si_wrap)
);

// File: tb/limp_sig_gen_bench.sv
`timescale 1ns/1ps
module limp_sig_gen_bench;
  localparam int CLK_HZ = 2000;
  localparam int SI_P = CLK_HZ * 4 / 5;
  localparam int SI_L = CLK_HZ * 2 / 5;
  localparam int PL_P = CLK_HZ / 100;
  localparam int PL_L = CLK_HZ / 500;

  logic clk = 0, rst_n = 0;
  logic wd_fail = 0, wd_ok = 0, two_fail_cfg = 0, force_on = 0, clear = 0;
  logic si_drive_low, pl_drive_low, limp_active;
  int checks = 0, fails = 0;
  int idx = 0;
  bit timed_out = 0;

  always #4 clk = ~clk;

  limp_sig_gen #(.CLK_HZ(CLK_HZ)) u_limp_sig_gen (
    .clk(clk), .rst_n(rst_n), .wd_fail(wd_fail), .wd_ok(wd_ok),
    .two_fail_cfg(two_fail_cfg), .force_on(force_on), .clear(clear),
    .si_drive_low(si_drive_low), .pl_drive_low(pl_drive_low),
    .limp_active(limp_active)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle pulse; returns at the negedge after the capturing edge
  task automatic pulse_fail();  @(negedge clk) wd_fail = 1;  @(negedge clk) wd_fail = 0;  endtask
  task automatic pulse_ok();    @(negedge clk) wd_ok = 1;    @(negedge clk) wd_ok = 0;    endtask
  task automatic pulse_force(); @(negedge clk) force_on = 1; @(negedge clk) force_on = 0; endtask
  task automatic pulse_clear(); @(negedge clk) clear = 1;    @(negedge clk) clear = 0;    endtask

  function automatic bit exp_si(input int i); return (i % SI_P) < SI_L; endfunction
  function automatic bit exp_pl(input int i); return (i % PL_P) < PL_L; endfunction

  // compare n cycles starting at the current negedge (phase idx)
  task automatic run_wave(input int n, output int si_bad, output int pl_bad);
    si_bad = 0; pl_bad = 0;
    for (int k = 0; k < n; k++) begin
      if (si_drive_low != exp_si(idx)) si_bad++;
      if (pl_drive_low != exp_pl(idx)) pl_bad++;
      @(negedge clk); idx++;
    end
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 limp_active after reset", limp_active, 0);
    check("R10 drives released after reset", {si_drive_low, pl_drive_low}, 0);
  endtask

  task automatic t_single_and_waves();
    int sb, pb;
    two_fail_cfg = 0;
    pulse_fail();
    check("R2 single failure activates", limp_active, 1);
    idx = 0;
    run_wave(2 * SI_P + 37, sb, pb);
    check("R6 side indicator mismatches", sb, 0);
    check("R7 lamp PWM mismatches", pb, 0);
  endtask

  task automatic t_phase_hold();
    int sb, pb, sb2, pb2;
    // inject failure and force mid-wave; phase must continue
    run_wave(13, sb, pb);
    @(negedge clk) wd_fail = 1; idx++;
    @(negedge clk) wd_fail = 0; force_on = 1; idx++;
    @(negedge clk) force_on = 0; idx++;
    run_wave(SI_P + 5, sb2, pb2);
    check("R8 phase kept after extra pulses (si)", sb + sb2, 0);
    check("R8 phase kept after extra pulses (pl)", pb + pb2, 0);
    check("R8 still active", limp_active, 1);
  endtask

  task automatic t_clear();
    pulse_clear();
    check("R9 clear deactivates", limp_active, 0);
    check("R10 drives released after clear", {si_drive_low, pl_drive_low}, 0);
    repeat (30) @(negedge clk);
    check("R10 drives stay released", {si_drive_low, pl_drive_low}, 0);
  endtask

  task automatic t_two_fail();
    two_fail_cfg = 1;
    pulse_fail();
    check("R3 first failure does not activate", limp_active, 0);
    pulse_fail();
    check("R3 second failure activates", limp_active, 1);
    pulse_clear();
    // clear resets the count: one failure must not activate
    pulse_fail();
    check("R9 clear resets failure count", limp_active, 0);
    pulse_ok();
    pulse_fail();
    check("R4 service between failures breaks run", limp_active, 0);
    pulse_fail();
    check("R4 next consecutive failure activates", limp_active, 1);
    pulse_clear();
  endtask

  task automatic t_force_and_priority();
    int sb, pb;
    two_fail_cfg = 1;
    pulse_force();
    check("R5 force activates", limp_active, 1);
    idx = 0;
    run_wave(3 * PL_P, sb, pb);
    check("R7 PWM after force", pb, 0);
    pulse_clear();
    two_fail_cfg = 0;
    @(negedge clk) begin clear = 1; wd_fail = 1; force_on = 1; end
    @(negedge clk) begin clear = 0; wd_fail = 0; force_on = 0; end
    check("R9 clear wins over fail and force", limp_active, 0);
    check("R9 drives released with clear priority", {si_drive_low, pl_drive_low}, 0);
  endtask

  initial begin
    t_reset();
    t_single_and_waves();
    t_phase_hold();
    t_clear();
    t_two_fail();
    t_force_and_priority();
    if (!timed_out) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule